// File: doc/BRIEF.md
# Full-Duplex Clocked Serial Shifter

This block is an 8-bit synchronous serial port. It sends one byte and receives one byte in the same transfer. A single data buffer serves both directions: the CPU writes the next byte to send into it, and the block overwrites it with each byte it receives. Bits leave on serial data out and arrive on serial data in, least-significant bit first. The outgoing bit changes when the serial clock falls, and the incoming bit is captured when the serial clock rises.

As clock master, the block makes the serial clock from a half-period divider count. After each byte it holds the clock high until the CPU has both read the received byte and written the next one. As slave, it follows an external serial clock, which passes through a two-flop synchroniser and is edge-detected on the system clock. In slave mode there is no wait state, so the CPU must service the buffer before the next external falling edge.

The CPU starts a transfer by raising a run-enable level. Lowering that level stops the port gracefully at the next byte boundary. A one-cycle abort pulse stops it at once. Each completed byte produces a one-cycle interrupt pulse. The state machine has three states:

- ST_IDLE: the port is stopped.
- ST_SHIFT: a byte is moving.
- ST_WAIT: the port is between bytes.

Its transitions are:

- IDLE→SHIFT: run is high and abort is low.
- SHIFT→WAIT: the byte completes while run is high.
- SHIFT→IDLE: the byte completes while run is low, or abort is asserted.
- WAIT→SHIFT: in master mode, the buffer has been both read and written; in slave mode, an external falling edge arrives.
- WAIT→IDLE: run is low, or abort is asserted.

Top module: `duplex_shifter`

## Requirements
- R1: After reset, and at any time the port is not busy, `busy`=0, `sclk_out`=1 (the clock idles high), `irq`=0, and after reset `sdo`=1 and `rd_data`=0.
- R2: In master mode, `sdo` changes only when `sclk_out` falls, and the bits of the transmitted byte leave least-significant bit first, one per clock period.
- R3: `sdi` is captured on each rising serial clock, least-significant bit first. After the eighth rising edge the received byte appears on `rd_data`, and `irq` is high for exactly one cycle.
- R4: In master mode, each half period of `sclk_out` lasts `half_div`+1 system clock cycles.
- R5: In master mode, after a byte completes with `start` still high, `sclk_out` stays high until both `rd_en` and `wr_en` have been pulsed since that byte's `irq`. A read alone does not release the clock.
- R6: In slave mode (`ext_mode`=1), shifting follows the falling and rising edges of `sclk_in` with no wait state. The next byte's bit 0 is taken from the buffer at the first `sclk_in` falling edge after a byte completes.
- R7: From the moment `start` is raised until the first falling serial clock edge, `sdo` keeps the last bit (bit 7) of the previously sent byte.
- R8: Lowering `start` during a byte lets that byte complete, deliver `rd_data`, and pulse `irq`. `busy` then drops.
- R9: An `abort` pulse drops `busy` in the next cycle and returns `sclk_out` high. The aborted byte produces no `irq`.
- R10: A change of `ext_mode` clears the data buffer to 0 and clears both service flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_mode | input | 1 | 1 = slave, clocked by `sclk_in`; 0 = master |
| half_div | input | DIV_W | Master half-period count minus one |
| start | input | 1 | Run enable level; lowering it requests a graceful stop |
| abort | input | 1 | Pulse: stop immediately |
| wr_en | input | 1 | Write strobe to the data buffer |
| wr_data | input | DATA_W | Byte to send next |
| rd_en | input | 1 | Marks the received byte as read |
| rd_data | output | DATA_W | Data buffer contents |
| busy | output | 1 | Transfer active (not idle) |
| irq | output | 1 | One-cycle pulse per completed byte |
| sclk_out | output | 1 | Serial clock in master mode; held high in slave mode |
| sclk_in | input | 1 | External serial clock, used in slave mode |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
A table of transmit/receive byte pairs runs back to back in master mode. The pairs include alternating, nibble-split, sparse and dense values, so that a reversed bit order, a missing shift, or a swapped direction gives a visibly different byte. The stall test separates a design that waits for both buffer services from one that resumes after only a read. A low first bit following a high last bit (and the reverse) shows whether `sdo` holds its previous value before the first falling edge. Slave-mode runs with two consecutive bytes show that the external clock alone paces the transfer and that the buffer is reloaded at the next falling edge.

// File: rtl/duplex_shifter_pkg.sv
package duplex_shifter_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_WAIT  = 2'd2
    } shift_state_e;
endpackage

// File: rtl/duplex_edge_sync.sv
module duplex_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise,
    output logic fall
);
    // pipe[STAGES-1:0] synchronise, pipe[STAGES] is the previous settled value
    logic [STAGES:0] pipe;

    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '1;
        else        pipe <= {pipe[STAGES-1:0], async_in};
    end

    assign rise =  pipe[STAGES-1] & ~pipe[STAGES];
    assign fall = ~pipe[STAGES-1] &  pipe[STAGES];
endmodule

// File: rtl/duplex_half_div.sv
module duplex_half_div #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         tick
);
    logic [W-1:0] cnt;

    assign tick = run && (cnt == limit);

    always_ff @(posedge clk) begin
        if (!rst_n)             cnt <= '0;
        else if (!run || tick)  cnt <= '0;
        else                    cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/duplex_shifter.sv
import duplex_shifter_pkg::*;

module duplex_shifter #(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_mode,
    input  logic [DIV_W-1:0]  half_div,
    input  logic              start,
    input  logic              abort,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              irq,
    output logic              sclk_out,
    input  logic              sclk_in,
    output logic              sdo,
    input  logic              sdi
);
    localparam int               CNT_W    = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    shift_state_e      state, nxt;
    logic              sclk_q;
    logic              sdo_q;
    logic [DATA_W-1:0] tx_sh;
    logic [DATA_W-1:0] rx_sh;
    logic [DATA_W-1:0] buf_q;
    logic [CNT_W-1:0]  bit_cnt;
    logic              got_read;
    logic              got_write;
    logic              irq_q;
    logic              mode_q;

    logic tick, ext_rise, ext_fall;
    logic fall_evt, rise_evt, byte_done, resume, div_run;

    duplex_edge_sync #(.STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (sclk_in),
        .rise     (ext_rise),
        .fall     (ext_fall)
    );

    assign div_run = (state == ST_SHIFT) && !ext_mode && !abort;

    duplex_half_div #(.W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (div_run),
        .limit (half_div),
        .tick  (tick)
    );

    assign fall_evt  = ext_mode ? ext_fall : (tick &&  sclk_q);
    assign rise_evt  = ext_mode ? ext_rise : (tick && !sclk_q);
    assign byte_done = (state == ST_SHIFT) && rise_evt && (bit_cnt == LAST_BIT);
    assign resume    = ext_mode ? ext_fall : (got_read && got_write);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start && !abort) nxt = ST_SHIFT;
            ST_SHIFT: begin
                if (abort)          nxt = ST_IDLE;
                else if (byte_done) nxt = start ? ST_WAIT : ST_IDLE;
            end
            ST_WAIT: begin
                if (abort || !start) nxt = ST_IDLE;
                else if (resume)     nxt = ST_SHIFT;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q    <= 1'b1;
            sdo_q     <= 1'b1;
            tx_sh     <= '0;
            rx_sh     <= '0;
            buf_q     <= '0;
            bit_cnt   <= '0;
            got_read  <= 1'b0;
            got_write <= 1'b0;
            irq_q     <= 1'b0;
            mode_q    <= 1'b0;
        end else begin
            irq_q  <= 1'b0;
            mode_q <= ext_mode;
            if (rd_en) got_read <= 1'b1;
            if (wr_en) begin
                buf_q     <= wr_data;
                got_write <= 1'b1;
            end
            unique case (state)
                ST_IDLE: begin
                    sclk_q  <= 1'b1;
                    bit_cnt <= '0;
                    if (nxt == ST_SHIFT) tx_sh <= buf_q;
                end
                ST_SHIFT: begin
                    if (abort) begin
                        sclk_q <= 1'b1;
                    end else if (fall_evt) begin
                        sdo_q <= tx_sh[0];
                        tx_sh <= tx_sh >> 1;
                        if (!ext_mode) sclk_q <= 1'b0;
                    end else if (rise_evt) begin
                        rx_sh   <= {sdi, rx_sh[DATA_W-1:1]};
                        bit_cnt <= bit_cnt + 1'b1;
                        if (!ext_mode) sclk_q <= 1'b1;
                        if (byte_done) begin
                            buf_q     <= {sdi, rx_sh[DATA_W-1:1]};
                            irq_q     <= 1'b1;
                            got_read  <= 1'b0;
                            got_write <= 1'b0;
                            bit_cnt   <= '0;
                        end
                    end
                end
                ST_WAIT: begin
                    sclk_q  <= 1'b1;
                    bit_cnt <= '0;
                    if (nxt == ST_SHIFT) begin
                        if (ext_mode) begin
                            sdo_q <= buf_q[0];
                            tx_sh <= buf_q >> 1;
                        end else begin
                            tx_sh <= buf_q;
                        end
                    end
                end
                default: sclk_q <= 1'b1;
            endcase
            if (ext_mode != mode_q) begin
                buf_q     <= '0;
                got_read  <= 1'b0;
                got_write <= 1'b0;
            end
        end
    end

    assign rd_data  = buf_q;
    assign busy     = (state != ST_IDLE);
    assign irq      = irq_q;
    assign sclk_out = ext_mode ? 1'b1 : sclk_q;
    assign sdo      = sdo_q;
endmodule

// File: rtl/duplex_shifter_chk.sv
import duplex_shifter_pkg::*;

module duplex_shifter_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         ext_mode,
    input logic         abort,
    input logic         busy,
    input logic         irq,
    input logic         sclk_out,
    input logic         sdo,
    input shift_state_e st
);
    p_idle_clk_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sclk_out);

    p_sdo_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_mode && $past(!ext_mode) && !$fell(sclk_out)) |-> $stable(sdo));

    p_irq_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    p_wait_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT && !ext_mode) |-> sclk_out);

    p_abort_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !busy);
endmodule

bind duplex_shifter duplex_shifter_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_mode (ext_mode),
    .abort    (abort),
    .busy     (busy),
    .irq      (irq),
    .sclk_out (sclk_out),
    .sdo      (sdo),
    .st       (state)
);

// File: tb/sim_duplex_shifter.sv
module sim_duplex_shifter;
    localparam int DW = 8;
    localparam int VW = 8;
    localparam logic [15:0] VEC [4] = '{16'h3CA5, 16'hF00F, 16'h8117, 16'h6C96};

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n, ext_mode, start, abort, wr_en, rd_en, sclk_in, sdi;
    logic [VW-1:0] half_div;
    logic [DW-1:0] wr_data, rd_data;
    logic          busy, irq, sclk_out, sdo;

    duplex_shifter #(.DATA_W(DW), .DIV_W(VW)) u0 (
        .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .half_div(half_div),
        .start(start), .abort(abort), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .busy(busy), .irq(irq),
        .sclk_out(sclk_out), .sclk_in(sclk_in), .sdo(sdo), .sdi(sdi)
    );

    int checks = 0, fails = 0, irq_cnt = 0, cyc = 0;

    always @(posedge clk) if (irq) irq_cnt++;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: run did not finish (actual cycles %0d, expected < 150000)", cyc);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cpu_wr(input logic [7:0] d);
        wr_data = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic cpu_rd();
        rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
    endtask

    // master-mode peer: feeds sdi after each fall, captures sdo at each rise
    task automatic serve_int(input logic [7:0] rxb, output logic [7:0] txcap,
                             output int lowlen, input int stop_after, input int abort_after);
        int   idx = 0;
        int   guard = 0;
        int   lowc = 0;
        logic prev = sclk_out;
        txcap = '0; lowlen = 0; sdi = rxb[0];
        while (idx < 8 && guard < 3000) begin
            @(negedge clk); guard++;
            if (prev && !sclk_out) begin sdi = rxb[idx]; lowc = 0; end
            if (!sclk_out) lowc++;
            if (!prev && sclk_out) begin
                txcap[idx] = sdo;
                if (idx == 0) lowlen = lowc;
                idx++;
                if (idx == stop_after) start = 1'b0;
                if (idx == abort_after) begin
                    abort = 1'b1; start = 1'b0;
                    @(negedge clk); abort = 1'b0;
                    idx = 8;
                end
            end
            prev = sclk_out;
        end
    endtask

    // slave-mode peer: drives sclk_in slowly
    task automatic serve_ext(input logic [7:0] rxb, output logic [7:0] txcap);
        txcap = '0;
        for (int i = 0; i < 8; i++) begin
            sclk_in = 1'b0; sdi = rxb[i];
            repeat (8) @(negedge clk);
            sclk_in = 1'b1;
            repeat (8) @(negedge clk);
            txcap[i] = sdo;
        end
    endtask

    initial begin
        logic [7:0] cap;
        int         lowlen;
        int         n0;
        logic       saw_low;

        rst_n = 1'b0; ext_mode = 1'b0; start = 1'b0; abort = 1'b0;
        wr_en = 1'b0; rd_en = 1'b0; sclk_in = 1'b1; sdi = 1'b0;
        wr_data = '0; half_div = 8'd3;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 sclk_out", sclk_out, 1);
        chk("R1 irq", irq, 0);
        chk("R1 sdo", sdo, 1);
        chk("R1 rd_data", rd_data, 0);

        // vector table, back to back with start held (R2 R3 R4 R5)
        for (int k = 0; k < 4; k++) begin
            if (k == 0) begin
                cpu_wr(VEC[k][15:8]); start = 1'b1;
            end else begin
                cpu_rd(); cpu_wr(VEC[k][15:8]);
            end
            serve_int(VEC[k][7:0], cap, lowlen, 9, 9);
            repeat (2) @(negedge clk);
            chk("R3 received byte", rd_data, VEC[k][7:0]);
            chk("R2 transmitted byte", cap, VEC[k][15:8]);
            chk("R3 irq count", irq_cnt, k + 1);
            if (k == 0) chk("R4 low half period", lowlen, 4);
        end

        // R5: no service, then read only: clock must stay high
        saw_low = 1'b0;
        for (int i = 0; i < 40; i++) begin @(negedge clk); if (!sclk_out) saw_low = 1'b1; end
        chk("R5 stall without service", saw_low, 0);
        chk("R5 busy while waiting", busy, 1);
        cpu_rd();
        for (int i = 0; i < 40; i++) begin @(negedge clk); if (!sclk_out) saw_low = 1'b1; end
        chk("R5 stall after read only", saw_low, 0);
        cpu_wr(8'h5A);
        serve_int(8'hC3, cap, lowlen, 9, 9);
        repeat (2) @(negedge clk);
        chk("R5 resumed tx", cap, 8'h5A);
        chk("R5 resumed rx", rd_data, 8'hC3);

        // R8 graceful stop from wait
        start = 1'b0;
        repeat (2) @(negedge clk);
        chk("R8 idle after stop in wait", busy, 0);

        // R7 sdo holds previous last bit (0x5A bit7 = 0) before first fall
        cpu_wr(8'h01); start = 1'b1;
        @(negedge clk);
        chk("R7 sdo held", sdo, 0);
        chk("R7 clock not yet fallen", sclk_out, 1);

        // R8 graceful stop mid-byte
        n0 = irq_cnt;
        serve_int(8'h7E, cap, lowlen, 3, 9);
        repeat (2) @(negedge clk);
        chk("R8 byte delivered", rd_data, 8'h7E);
        chk("R8 tx complete", cap, 8'h01);
        chk("R8 irq fired", irq_cnt, n0 + 1);
        chk("R8 busy cleared", busy, 0);

        // R9 abort mid-byte
        cpu_wr(8'hFF); start = 1'b1;
        n0 = irq_cnt;
        serve_int(8'h00, cap, lowlen, 9, 2);
        chk("R9 busy drops", busy, 0);
        chk("R9 clock high", sclk_out, 1);
        repeat (60) @(negedge clk);
        chk("R9 no irq", irq_cnt, n0);
        chk("R9 clock stays high", sclk_out, 1);

        // R10 mode change clears buffer
        chk("R10 buffer before switch", rd_data, 8'hFF);
        ext_mode = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10 buffer cleared", rd_data, 0);

        // R6 slave mode, two bytes
        cpu_wr(8'hB4); start = 1'b1;
        serve_ext(8'h2D, cap);
        repeat (2) @(negedge clk);
        chk("R6 slave rx byte 1", rd_data, 8'h2D);
        chk("R6 slave tx byte 1", cap, 8'hB4);
        cpu_rd(); cpu_wr(8'h69);
        serve_ext(8'h96, cap);
        repeat (2) @(negedge clk);
        chk("R6 slave rx byte 2", rd_data, 8'h96);
        chk("R6 slave tx byte 2", cap, 8'h69);
        chk("R6 slave sclk_out idle", sclk_out, 1);
        start = 1'b0;
        repeat (2) @(negedge clk);
        chk("R8 slave stop", busy, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule